// File: doc/BRIEF.md
# Power-On Fan Duty Initializer

This block decides which PWM duty a fan runs at when main power comes up. It sits in the standby-powered domain. Its two stored items are a one-byte duty value that software may write and a flag that records whether that value was ever written. The stored value and the flag outlive main-power cycles and are cleared only by the standby reset. An external strap pin picks the fallback duty when nothing was stored. The block latches that pin at the moment main power becomes good and shows the latched level in a status register.

When power-good rises, the block gives the PWM generator one 8-bit initial duty together with a single-cycle valid pulse. It then raises a hand-off signal so that normal fan control takes over. While power-good is low, the duty output stays at full speed.

The controller has three states:
- `ST_OFF` means main power is absent.
- `ST_LOAD` is the one cycle in which the initial duty is presented.
- `ST_RUN` means control has been handed off.

The transitions are:
- OFF→LOAD on the first clock that samples power-good high.
- LOAD→RUN if power-good is still high.
- LOAD→OFF and RUN→OFF when power-good is sampled low.

Register map:
- Address 0x0 is the stored duty byte, readable and writable.
- Address 0x1 is read-only status. Bit 0 is the latched strap and bit 1 is the programmed flag.
- Every other address reads as zero.

Top module: `fan_boot_duty`

## Requirements
- R1: After standby reset the stored duty reads 0x66, the programmed flag (status bit 1) reads 0, the latched strap (status bit 0) reads 1, duty_out is 0xFF, and duty_vld and ctrl_handoff are 0.
- R2: A write to address 0x0 replaces the stored duty, which reads back from 0x0 on the next cycle, and sets status bit 1.
- R3: When power-good is sampled low at a clock edge, from the following cycle duty_out is 0xFF and duty_vld and ctrl_handoff are 0.
- R4: In the cycle after the first edge that samples power-good high in ST_OFF, duty_vld is 1 for exactly one cycle.
- R5: If status bit 1 is set at that edge, the initial duty equals the stored duty.
- R6: If status bit 1 is clear and the strap is 0 at that edge, the initial duty is 0xFF.
- R7: If status bit 1 is clear and the strap is 1 at that edge, the initial duty is 0x66.
- R8: The strap level is copied into status bit 0 only at the power-up edge. Strap changes at any other time leave status bit 0 unchanged.
- R9: After the valid cycle, while power-good stays high, ctrl_handoff is 1 and duty_out holds the initial duty.
- R10: The stored duty and status bit 1 keep their values across any number of power-good cycles and are cleared only by standby reset.
- R11: Writes to address 0x1 or to unmapped addresses change no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| sb_rst_n | input | 1 | Standby reset, active low, asynchronous |
| pwr_good | input | 1 | Main power good |
| strap_in | input | 1 | Fallback-select strap, 1 = 40 %, 0 = 100 % |
| reg_addr | input | 4 | Register address, for both reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| duty_out | output | 8 | Duty value sent to the PWM generator |
| duty_vld | output | 1 | One-cycle pulse that marks the initial duty |
| ctrl_handoff | output | 1 | High once normal fan control owns the duty |

## Verification
Every result registers at one clock edge and appears one cycle later:
- A write reaches the read data on the cycle after the edge that samples it.
- The initial duty and its valid pulse follow the first edge that samples power-good high.
- The hand-off signal rises one cycle after that.
- A drop of power-good forces full duty on the cycle after the edge that samples it.

The bench drives inputs on the falling edge. A behavioural model advances at each rising edge using the same sampled inputs, and every output is compared 2 ns after that rising edge. Each expected value is therefore read exactly one register stage after its cause. Directed checks at those same sample points cover the strap, the flag and the write-ignore cases.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
    localparam int DUTY_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_DUTY = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 4'h1;

    localparam logic [DUTY_W-1:0] DUTY_FULL  = 8'hFF;
    localparam logic [DUTY_W-1:0] DUTY_FORTY = 8'h66;
    localparam logic [DUTY_W-1:0] DUTY_RST   = 8'h66;

    localparam int STAT_STRAP_BIT = 0;
    localparam int STAT_PROG_BIT  = 1;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } boot_state_t;
endpackage

// File: rtl/fbd_regs.sv
module fbd_regs
    import fbd_pkg::*;
#(
    parameter int DW = DUTY_W,
    parameter int AW = ADDR_W,
    parameter logic [DW-1:0] RST_VAL = DUTY_RST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          strap_bit,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] stored_duty,
    output logic          prog_flag
);
    logic duty_hit;
    logic [DW-1:0] stat_word;

    assign duty_hit = wr && (addr == ADDR_DUTY[AW-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_duty <= RST_VAL;
            prog_flag   <= 1'b0;
        end else if (duty_hit) begin
            stored_duty <= wdata;
            prog_flag   <= 1'b1;
        end
    end

    always_comb begin
        stat_word = '0;
        stat_word[STAT_STRAP_BIT] = strap_bit;
        stat_word[STAT_PROG_BIT]  = prog_flag;
    end

    always_comb begin
        unique case (addr)
            ADDR_DUTY[AW-1:0]: rdata = stored_duty;
            ADDR_STAT[AW-1:0]: rdata = stat_word;
            default:           rdata = '0;
        endcase
    end

    // R2
    flag_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_hit |=> (prog_flag && stored_duty == $past(wdata)));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_flag |=> prog_flag);

    // R11
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != ADDR_DUTY[AW-1:0]) |=> $stable(stored_duty));
endmodule

// File: rtl/fbd_strap.sv
module fbd_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic strap_in,
    output logic strap_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       strap_q <= 1'b1;
        else if (capture) strap_q <= strap_in;
    end

    // R8
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(strap_q));
endmodule

// File: rtl/fbd_sel.sv
module fbd_sel
    import fbd_pkg::*;
#(
    parameter int DW = DUTY_W,
    parameter logic [DW-1:0] FULL_VAL  = DUTY_FULL,
    parameter logic [DW-1:0] FORTY_VAL = DUTY_FORTY
) (
    input  logic          prog_flag,
    input  logic [DW-1:0] stored_duty,
    input  logic          strap,
    output logic [DW-1:0] init_duty
);
    logic [DW-1:0] fallback;

    assign fallback  = strap ? FORTY_VAL : FULL_VAL;
    assign init_duty = prog_flag ? stored_duty : fallback;
endmodule

// File: rtl/fbd_fsm.sv
module fbd_fsm
    import fbd_pkg::*;
#(
    parameter int DW = DUTY_W,
    parameter logic [DW-1:0] FULL_VAL = DUTY_FULL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic [DW-1:0] init_duty,
    output logic          load_en,
    output logic [DW-1:0] duty_out,
    output logic          duty_vld,
    output logic          handoff
);
    boot_state_t state, state_nx;
    logic [DW-1:0] duty_q;

    assign load_en = (state == ST_OFF) && pwr_good;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (pwr_good) state_nx = ST_LOAD;
            ST_LOAD: state_nx = pwr_good ? ST_RUN : ST_OFF;
            ST_RUN:  if (!pwr_good) state_nx = ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       duty_q <= FULL_VAL;
        else if (load_en) duty_q <= init_duty;
    end

    always_comb begin
        duty_out = FULL_VAL;
        duty_vld = 1'b0;
        handoff  = 1'b0;
        unique case (state)
            ST_OFF:  duty_out = FULL_VAL;
            ST_LOAD: begin duty_out = duty_q; duty_vld = 1'b1; end
            ST_RUN:  begin duty_out = duty_q; handoff  = 1'b1; end
            default: duty_out = FULL_VAL;
        endcase
    end

    // R4
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_vld |=> !duty_vld);

    // R4
    load_follows_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> duty_vld);

    // R9
    handoff_after_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_vld && pwr_good) |=> (handoff && $stable(duty_out)));
endmodule

// File: rtl/fan_boot_duty.sv
module fan_boot_duty
    import fbd_pkg::*;
#(
    parameter int DW = DUTY_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          sb_rst_n,
    input  logic          pwr_good,
    input  logic          strap_in,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_wr,
    output logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] duty_out,
    output logic          duty_vld,
    output logic          ctrl_handoff
);
    logic          load_en;
    logic          strap_q;
    logic          prog_flag;
    logic [DW-1:0] stored_duty;
    logic [DW-1:0] init_duty;

    fbd_regs #(.DW(DW), .AW(AW), .RST_VAL(DUTY_RST)) regs_i (
        .clk(clk), .rst_n(sb_rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .wr(reg_wr), .strap_bit(strap_q), .rdata(reg_rdata),
        .stored_duty(stored_duty), .prog_flag(prog_flag)
    );

    fbd_strap strap_i (
        .clk(clk), .rst_n(sb_rst_n), .capture(load_en),
        .strap_in(strap_in), .strap_q(strap_q)
    );

    fbd_sel #(.DW(DW), .FULL_VAL(DUTY_FULL), .FORTY_VAL(DUTY_FORTY)) sel_i (
        .prog_flag(prog_flag), .stored_duty(stored_duty),
        .strap(strap_in), .init_duty(init_duty)
    );

    fbd_fsm #(.DW(DW), .FULL_VAL(DUTY_FULL)) fsm_i (
        .clk(clk), .rst_n(sb_rst_n), .pwr_good(pwr_good),
        .init_duty(init_duty), .load_en(load_en), .duty_out(duty_out),
        .duty_vld(duty_vld), .handoff(ctrl_handoff)
    );

    // R3
    off_full_duty_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
        !pwr_good |=> (duty_out == DUTY_FULL && !duty_vld && !ctrl_handoff));

    // R5
    stored_used_chk: assert property (@(posedge clk) disable iff (!sb_rst_n)
        (load_en && prog_flag) |=> (duty_out == $past(stored_duty)));
endmodule

// File: tb/fan_boot_duty_tb.sv
module fan_boot_duty_tb_top;
    logic       clk = 1'b0;
    logic       sb_rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       strap_in = 1'b1;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_rdata, duty_out;
    logic       duty_vld, ctrl_handoff;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;
    bit started = 0;

    // behavioural reference
    int m_ph = 0;
    int m_stored = 'h66;
    int m_flag = 0;
    int m_strap = 1;
    int m_init = 'hFF;

    always #4 clk = ~clk;

    fan_boot_duty dut_i (
        .clk(clk), .sb_rst_n(sb_rst_n), .pwr_good(pwr_good), .strap_in(strap_in),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rdata(reg_rdata), .duty_out(duty_out), .duty_vld(duty_vld),
        .ctrl_handoff(ctrl_handoff)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_read(input int a);
        if (a == 0) return m_stored;
        if (a == 1) return (m_flag << 1) | m_strap;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!sb_rst_n) begin
            m_stored = 'h66; m_flag = 0; m_strap = 1; m_ph = 0; m_init = 'hFF;
            started = 1;
        end else begin
            if (m_ph == 0) begin
                if (pwr_good) begin
                    m_init = m_flag ? m_stored : (strap_in ? 'h66 : 'hFF);
                    m_strap = strap_in;
                    m_ph = 1;
                end
            end else if (m_ph == 1) m_ph = pwr_good ? 2 : 0;
            else if (!pwr_good) m_ph = 0;
            if (reg_wr && reg_addr == 4'h0) begin
                m_stored = reg_wdata; m_flag = 1;
            end
        end
    end

    always @(posedge clk) begin
        #2;
        if (started && !done) begin
            check(m_ph == 0 ? "R3" : (m_ph == 1 ? "R4" : "R9"), duty_out, m_ph == 0 ? 'hFF : m_init);
            check("R4", duty_vld, m_ph == 1);
            check("R9", ctrl_handoff, m_ph == 2);
            check("R2", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic rd(input logic [3:0] a, input string tag, input int exp);
        @(negedge clk); reg_addr = a; #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic power_up(input string tag, input int exp);
        @(negedge clk); pwr_good = 1'b1;
        step();
        check(tag, duty_out, exp);
        check("R4", duty_vld, 1);
        step();
        check("R4", duty_vld, 0);
        check("R9", ctrl_handoff, 1);
        check("R9", duty_out, exp);
    endtask

    task automatic power_down();
        @(negedge clk); pwr_good = 1'b0;
        step();
        check("R3", duty_out, 'hFF);
        check("R3", ctrl_handoff, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        sb_rst_n = 1'b1;
        // R1 defaults
        rd(4'h0, "R1", 'h66);
        rd(4'h1, "R1", 'h01);
        check("R1", duty_out, 'hFF);
        check("R1", duty_vld, 0);
        // R7 strap high, unprogrammed
        power_up("R7", 'h66);
        @(negedge clk); strap_in = 1'b0;
        repeat (3) step();
        rd(4'h1, "R8", 'h01);
        power_down();
        // R6 strap low, unprogrammed
        power_up("R6", 'hFF);
        rd(4'h1, "R8", 'h00);
        power_down();
        // R11 ignored writes
        wr(4'h1, 8'hAA);
        rd(4'h1, "R11", 'h00);
        wr(4'h7, 8'h55);
        rd(4'h0, "R11", 'h66);
        rd(4'h7, "R11", 'h00);
        // R2 write duty
        wr(4'h0, 8'h3C);
        rd(4'h0, "R2", 'h3C);
        rd(4'h1, "R2", 'h02);
        // R5 stored value used
        @(negedge clk); strap_in = 1'b1;
        power_up("R5", 'h3C);
        power_down();
        // R10 survives power cycling
        power_up("R10", 'h3C);
        rd(4'h1, "R10", 'h03);
        power_down();
        // single-cycle power-good glitch: LOAD then OFF
        @(negedge clk); pwr_good = 1'b1;
        @(negedge clk); pwr_good = 1'b0;
        step();
        check("R3", duty_out, 'hFF);
        check("R4", duty_vld, 0);
        // R10 standby reset clears
        @(negedge clk); sb_rst_n = 1'b0;
        @(negedge clk); sb_rst_n = 1'b1;
        rd(4'h0, "R10", 'h66);
        rd(4'h1, "R10", 'h01);
        power_up("R7", 'h66);
        repeat (4) step();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule